// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block chooses which of a small set of DMA channels is served next and reports when each channel reaches the end of its programmed transfer. Peripherals raise and drop per-channel service requests through hold and release strobes. A host-side mask vector can block any channel. Whenever a request changes, or a host write asks for a fresh look, the scheduler makes a pass over the channels. It visits them one per clock, from the lowest index to the highest. While it visits an unmasked channel with a pending request, it raises a grant and presents that channel's stored position and transfer length to the transfer agent.

In the same cycle the transfer agent answers with a progress report. The scheduler stores that value as the channel's new position. If the value equals the transfer length, a one-cycle terminal-count pulse goes to the status logic. The transfer length is the programmed base count plus one, shifted left by one when the controller moves words instead of bytes.

A pass that served any channel is followed at once by another pass. A trigger that arrives during a pass never restarts the walk; it only queues one more pass. A pass that serves nothing and has nothing queued returns the scheduler to idle.

Top module: `dma_svc_sched`

## Requirements
- R1: A grant for channel n is given only while mask_i[n] is 0 and request bit n (req_o[n]) is 1; grant_ch_o carries n.
- R2: A pass visits channels 0, 1, ..., NCH-1 in ascending order, one channel per clock cycle, and always starts at channel 0.
- R3: While a grant is up, grant_len_o equals (base count of the granted channel + 1) shifted left by wide_i (0 for byte, 1 for word). The base count of channel n occupies bits [n*CW +: CW] of base_cnt_i.
- R4: If prog_vld_i is 1 during a grant and prog_pos_i equals grant_len_o, then tc_o[granted channel] is 1 for exactly the next cycle. tc_o is 0 at all other times.
- R5: hold_i[n] sets req_o[n] and release_i[n] clears it, both from the next cycle. If both are set in the same cycle, the hold wins.
- R6: A pass starts in the cycle after a trigger (any hold, any release, or rescan_i) seen while idle. A trigger seen during a pass does not restart it; it queues one further pass that starts right after the current one.
- R7: If any channel was granted during a pass, another pass starts right after the last channel of that pass.
- R8: A progress report (prog_vld_i during a grant) replaces the stored position of the granted channel. That value appears on grant_pos_o at the channel's next grant. Without a report, the position is kept.
- R9: While busy_o is 0, grant_o is 0. A pass with no grant and no queued trigger ends with busy_o low in the following cycle.
- R10: After reset, busy_o, grant_o, req_o and tc_o are 0 and every stored position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_i | input | NCH | Per-channel mask, 1 blocks service |
| hold_i | input | NCH | Per-channel request set strobe |
| release_i | input | NCH | Per-channel request clear strobe |
| rescan_i | input | 1 | Request a scheduling pass |
| wide_i | input | 1 | Width shift: 0 byte controller, 1 word controller |
| base_cnt_i | input | NCH*CW | Programmed base counts, channel n at [n*CW +: CW] |
| prog_vld_i | input | 1 | Progress report valid from transfer agent |
| prog_pos_i | input | CW+2 | Reported new position of granted channel |
| req_o | output | NCH | Pending request bits |
| busy_o | output | 1 | A scheduling pass is running |
| grant_o | output | 1 | Channel grant strobe |
| grant_ch_o | output | log2(NCH) | Index of granted channel |
| grant_pos_o | output | CW+2 | Stored position of granted channel |
| grant_len_o | output | CW+2 | Transfer length of granted channel |
| tc_o | output | NCH | Terminal-count pulses |

## Verification
The assertions assume that the transfer agent raises prog_vld_i only while grant_o is high, and that mask_i, base_cnt_i and wide_i stay constant within a clock period. The bench meets both assumptions. Every input changes a fixed delay after the falling edge, and the modelled agent answers only after it has seen a grant in the current cycle. The agent never reports a position beyond grant_len_o, so reports and the terminal-count pulses they cause follow the behaviour the checks expect.

// File: rtl/dma_svc_sched.sv
module dma_svc_sched #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            mask_i,
  input  logic [NCH-1:0]            hold_i,
  input  logic [NCH-1:0]            release_i,
  input  logic                      rescan_i,
  input  logic                      wide_i,
  input  logic [NCH*CW-1:0]         base_cnt_i,
  input  logic                      prog_vld_i,
  input  logic [CW+1:0]             prog_pos_i,
  output logic [NCH-1:0]            req_o,
  output logic                      busy_o,
  output logic                      grant_o,
  output logic [$clog2(NCH)-1:0]    grant_ch_o,
  output logic [CW+1:0]             grant_pos_o,
  output logic [CW+1:0]             grant_len_o,
  output logic [NCH-1:0]            tc_o
);
  localparam int IW = $clog2(NCH);
  localparam int PW = CW + 2;
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  logic [NCH-1:0] req_q, tc_q;
  logic           busy_q, pend_q, svc_q;
  logic [IW-1:0]  idx_q;
  logic [PW-1:0]  pos_q [NCH];

  logic          trig, elig, again;
  logic [CW-1:0] base_sel;

  assign trig     = (|hold_i) | (|release_i) | rescan_i;
  assign elig     = !mask_i[idx_q] && req_q[idx_q];
  assign base_sel = base_cnt_i[idx_q*CW +: CW];
  assign again    = pend_q | trig | svc_q | grant_o;

  assign grant_o     = busy_q && elig;
  assign grant_ch_o  = idx_q;
  assign grant_pos_o = pos_q[idx_q];
  assign grant_len_o = (PW'(base_sel) + PW'(1)) << wide_i;
  assign req_o       = req_q;
  assign busy_o      = busy_q;
  assign tc_o        = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      tc_q   <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
      idx_q  <= '0;
      for (int i = 0; i < NCH; i++) pos_q[i] <= '0;
    end else begin
      req_q <= (req_q & ~release_i) | hold_i;
      tc_q  <= '0;
      if (grant_o && prog_vld_i) begin
        pos_q[idx_q] <= prog_pos_i;
        if (prog_pos_i == grant_len_o) tc_q[idx_q] <= 1'b1;
      end
      if (!busy_q) begin
        if (trig) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          pend_q <= 1'b0;
          svc_q  <= 1'b0;
        end
      end else if (idx_q == LAST) begin
        idx_q  <= '0;
        pend_q <= 1'b0;
        svc_q  <= 1'b0;
        busy_q <= again;
      end else begin
        idx_q  <= idx_q + IW'(1);
        pend_q <= pend_q | trig;
        svc_q  <= svc_q | grant_o;
      end
    end
  end
endmodule

// File: rtl/dma_svc_sched_chk.sv
module dma_svc_sched_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         mask_i,
  input logic [NCH-1:0]         hold_i,
  input logic                   prog_vld_i,
  input logic [NCH-1:0]         req_o,
  input logic                   busy_o,
  input logic                   grant_o,
  input logic [$clog2(NCH)-1:0] grant_ch_o,
  input logic [NCH-1:0]         tc_o,
  input logic [$clog2(NCH)-1:0] scan_idx
);
  localparam int IW = $clog2(NCH);

  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (!mask_i[grant_ch_o] && req_o[grant_ch_o]));

  a_r2_ascending_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && scan_idx != IW'(NCH - 1)) |=> (busy_o && scan_idx == IW'($past(scan_idx) + 1'b1)));

  a_r4_tc_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o != '0) |-> ($onehot0(tc_o) && $past(grant_o) && $past(prog_vld_i)));

  a_r5_hold_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i != '0) |=> ((req_o & $past(hold_i)) == $past(hold_i)));

  a_r6_pass_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (!busy_o || scan_idx == '0));

  a_r7_rearm_after_service: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && grant_o && scan_idx == IW'(NCH - 1)) |=> (busy_o && scan_idx == '0));

  a_r9_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !grant_o);
endmodule

bind dma_svc_sched dma_svc_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .hold_i(hold_i),
  .prog_vld_i(prog_vld_i), .req_o(req_o), .busy_o(busy_o), .grant_o(grant_o),
  .grant_ch_o(grant_ch_o), .tc_o(tc_o), .scan_idx(idx_q)
);

// File: tb/sim_dma_svc_sched.sv
`timescale 1ns/1ps
module sim_dma_svc_sched;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] mask_i = '0, hold_i = '0, release_i = '0;
  logic rescan_i = 0, wide_i = 0, prog_vld_i = 0;
  logic [NCH*CW-1:0] base_cnt_i;
  logic [CW+1:0] prog_pos_i = '0;
  logic [NCH-1:0] req_o, tc_o;
  logic busy_o, grant_o;
  logic [1:0] grant_ch_o;
  logic [CW+1:0] grant_pos_o, grant_len_o;

  int base [NCH] = '{0, 0, 0, 0};
  int n_chk = 0, n_fail = 0, cycles = 0;
  int step = 1;
  bit skip = 0, run_chk = 0;

  int m_req [NCH], m_pos [NCH], m_tc [NCH];
  int m_busy, m_pend, m_svc, m_idx;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NCH; i++) base_cnt_i[i*CW +: CW] = CW'(base[i]);

  dma_svc_sched #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .hold_i(hold_i), .release_i(release_i),
    .rescan_i(rescan_i), .wide_i(wide_i), .base_cnt_i(base_cnt_i), .prog_vld_i(prog_vld_i),
    .prog_pos_i(prog_pos_i), .req_o(req_o), .busy_o(busy_o), .grant_o(grant_o),
    .grant_ch_o(grant_ch_o), .grant_pos_o(grant_pos_o), .grant_len_o(grant_len_o), .tc_o(tc_o)
  );

  function automatic int len_of(int ch);
    return (base[ch] + 1) << wide_i;
  endfunction

  function automatic bit exp_grant();
    return m_busy != 0 && mask_i[m_idx] == 0 && m_req[m_idx] != 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_req[i]) begin m_req[i] = 0; m_pos[i] = 0; m_tc[i] = 0; end
      m_busy = 0; m_pend = 0; m_svc = 0; m_idx = 0;
    end else begin
      bit g, trig;
      g = exp_grant();
      trig = (hold_i != 0) || (release_i != 0) || rescan_i;
      foreach (m_tc[i]) m_tc[i] = 0;
      if (g && prog_vld_i) begin
        m_pos[m_idx] = int'(prog_pos_i);
        if (int'(prog_pos_i) == len_of(m_idx)) m_tc[m_idx] = 1;
      end
      if (m_busy == 0) begin
        if (trig) begin m_busy = 1; m_idx = 0; m_pend = 0; m_svc = 0; end
      end else if (m_idx == NCH - 1) begin
        m_busy = (m_pend != 0 || trig || m_svc != 0 || g) ? 1 : 0;
        m_idx = 0; m_pend = 0; m_svc = 0;
      end else begin
        m_idx++;
        if (trig) m_pend = 1;
        if (g) m_svc = 1;
      end
      foreach (m_req[i]) begin
        if (release_i[i]) m_req[i] = 0;
        if (hold_i[i]) m_req[i] = 1;
      end
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) if (run_chk && rst_n) begin
    bit eg;
    eg = exp_grant();
    check("R1 grant", int'(grant_o), int'(eg));
    check("R6 R7 R9 busy", int'(busy_o), m_busy);
    for (int i = 0; i < NCH; i++) begin
      check("R5 req", int'(req_o[i]), m_req[i]);
      check("R4 tc", int'(tc_o[i]), m_tc[i]);
    end
    if (eg) begin
      check("R2 grant_ch", int'(grant_ch_o), m_idx);
      check("R8 grant_pos", int'(grant_pos_o), m_pos[m_idx]);
      check("R3 grant_len", int'(grant_len_o), len_of(m_idx));
    end
  end

  // transfer agent: answers a grant within the same cycle
  always @(negedge clk) begin
    #3;
    if (grant_o && !skip) begin
      int np;
      np = int'(grant_pos_o) + step;
      if (np > int'(grant_len_o)) np = int'(grant_len_o);
      prog_vld_i = 1;
      prog_pos_i = (CW+2)'(np);
    end else begin
      prog_vld_i = 0;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic [NCH-1:0] h, logic [NCH-1:0] r, logic s);
    @(negedge clk); #2;
    hold_i = h; release_i = r; rescan_i = s;
    @(negedge clk); #2;
    hold_i = '0; release_i = '0; rescan_i = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
        finish_run();
      end
    end
  end

  initial begin
    wait_cyc(3);
    // R10: reset state
    check("R10 busy", int'(busy_o), 0);
    check("R10 grant", int'(grant_o), 0);
    check("R10 req", int'(req_o), 0);
    check("R10 tc", int'(tc_o), 0);
    #2 rst_n = 1;
    run_chk = 1;

    // byte controller, one channel running to terminal count and beyond (R3 R4 R7 R8)
    base[2] = 3; wide_i = 0; step = 1;
    drive(4'b0100, 4'b0000, 0);
    wait_cyc(40);
    drive(4'b0000, 4'b0100, 0);
    wait_cyc(12);
    check("R9 idle after release", int'(busy_o), 0);

    // masked request: no grant, pass ends (R1 R9)
    mask_i = 4'b0010;
    drive(4'b0010, 4'b0000, 0);
    wait_cyc(12);
    check("R9 masked idle", int'(busy_o), 0);
    check("R5 req kept while masked", int'(req_o[1]), 1);
    drive(4'b0000, 4'b0010, 0);
    wait_cyc(10);
    mask_i = 4'b0000;

    // word controller, three channels in order, agent pauses (R2 R3 R8)
    base[0] = 1; base[1] = 0; base[3] = 2; wide_i = 1; step = 2;
    drive(4'b1011, 4'b0000, 0);
    wait_cyc(10);
    skip = 1;
    wait_cyc(8);
    skip = 0;
    wait_cyc(20);
    mask_i = 4'b0001;
    wait_cyc(8);
    mask_i = 4'b0000;
    drive(4'b0000, 4'b1011, 0);
    wait_cyc(12);

    // triggers during a pass queue one more pass (R6)
    drive(4'b0000, 4'b0000, 1);
    drive(4'b0000, 4'b0000, 1);
    wait_cyc(15);
    check("R6 idle after queued pass", int'(busy_o), 0);

    // hold and release together: hold wins (R5)
    wide_i = 0; base[0] = 0; step = 1;
    drive(4'b0001, 4'b0001, 0);
    check("R5 hold wins", int'(req_o[0]), 1);
    wait_cyc(10);
    drive(4'b0000, 4'b0001, 0);
    wait_cyc(12);
    check("R9 final idle", int'(busy_o), 0);

    finish_run();
  end
endmodule